// File: doc/BRIEF.md
# Serial Flash Command Gate and Busy Tracker

This block sits between the serial command shifter of a page-organised serial flash and the rest of the device. It follows the chip-select framing and takes one decoded command class per frame. From the write-protect pin, a per-sector protection map and the current busy state, it decides whether that command may proceed. A verdict pulse reports the decision one clock after the command strobe.

Accepted commands take effect when chip select returns high. Program, erase and page-to-buffer transfer commands then start a self-timed stand-in operation. That operation lasts a fixed number of core clocks and holds the active-low ready/busy output low. It also flags which of the two SRAM buffers it occupies, so the other buffer stays usable. The block also owns the protection map, a sticky per-sector lock set, and the software protection enable. A low level on the reset pin aborts the running operation and any pending command, but leaves the protection state alone.

Top module: `flash_op_gate`

## Requirements
- R1: Exactly one of `cmd_acc` / `cmd_rej` pulses, for one cycle, in the cycle after the first `cmd_vld` sampled inside an open frame. A strobe given while `cs_n` is high, or any later strobe in the same frame, produces no pulse and no effect.
- R2: A frame opens only when the clock sees `cs_n` go from high to low. If `cs_n` is already low when `rst_n` is released, no frame is open until `cs_n` has been high.
- R3: Class encoding: 0 array read, 1 buffer access, 2 page program, 3 erase, 4 page-to-buffer transfer, 5 protection enable, 6 sector lockdown, 7 protection-map write. When the device is idle, `wp_n` is high and nothing is protected, every class is accepted.
- R4: An accepted class 2, 3 or 4 command starts the self-timed operation at the `cs_n` rising edge. `rdy_bsy` is low from the next sample for exactly `OP_CYCLES` cycles, whatever `cs_n` does meanwhile.
- R5: During a class 2 or 4 operation, `buf_lock` has only bit `cmd_buf` set. During a class 3 operation, `buf_lock` is zero. `buf_lock` never has more than one bit set.
- R6: While busy, a class 1 command to the unlocked buffer is accepted. Every other command is rejected, including a class 1 command to the locked buffer.
- R7: With `wp_n` low, class 2 and 3 commands are rejected and start no operation.
- R8: With `wp_n` low, class 5 and 6 commands are still accepted.
- R9: A class 7 command is rejected while `wp_n` is low. When accepted, `sect_prot` becomes `cmd_wdata` OR the locked sectors at the `cs_n` rise.
- R10: With `wp_n` high and `prot_on` set, a class 2 or 3 command to a sector whose `sect_prot` bit is 1 is rejected. With `prot_on` clear, the same command is accepted.
- R11: Class 5 sets `prot_on`. Class 6 sets `sect_prot[cmd_sect]` permanently, so that no later class 7 write clears it.
- R12: `rst_pin_n` low ends any busy state, clears `buf_lock` and discards a pending command by the next sample. `sect_prot` and `prot_on` are kept.
- R13: While `rst_n` is low, `rdy_bsy` is 1 and `buf_lock`, `cmd_acc`, `cmd_rej`, `sect_prot` and `prot_on` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low core reset |
| cs_n | input | 1 | Chip select, active low, synchronous to clk |
| cmd_vld | input | 1 | Decoded command strobe from the shifter |
| cmd_cls | input | 3 | Command class (encoding in R3) |
| cmd_sect | input | $clog2(N_SECT) | Target sector for program, erase and lockdown |
| cmd_buf | input | $clog2(N_BUF) | SRAM buffer used by the command |
| cmd_wdata | input | N_SECT | New protection map for class 7 |
| wp_n | input | 1 | Write-protect pin, active low |
| rst_pin_n | input | 1 | Device reset pin, active low, synchronous abort |
| rdy_bsy | output | 1 | Ready/busy, low while a self-timed operation runs |
| buf_lock | output | N_BUF | One-hot flag of the buffer held by the operation |
| cmd_acc | output | 1 | Command accepted pulse |
| cmd_rej | output | 1 | Command rejected pulse |
| sect_prot | output | N_SECT | Per-sector protection map |
| prot_on | output | 1 | Software protection enabled |

## Verification
The bench builds the block with `OP_CYCLES` set to 24 and keeps the default of 16 sectors and two buffers. A 24-cycle operation is long enough for three complete command frames to be opened and closed while busy is still low. That allows the buffer-lock rules and the continuation of an operation after chip select rises to be checked in the middle of a single operation. The window is still short enough that its full length can be counted cycle by cycle. With 16 sectors, the lockdown of a high sector index and a map write can be told apart bit by bit.

// File: rtl/flash_gate_pkg.sv
package flash_gate_pkg;

  typedef enum logic [2:0] {
    CL_ARR_RD   = 3'd0,
    CL_BUF_ACC  = 3'd1,
    CL_PROG     = 3'd2,
    CL_ERASE    = 3'd3,
    CL_XFER     = 3'd4,
    CL_PROT_EN  = 3'd5,
    CL_LOCKDN   = 3'd6,
    CL_PREG_WR  = 3'd7
  } cmd_cls_e;

  function automatic logic cls_timed(input cmd_cls_e c);
    return (c == CL_PROG) || (c == CL_ERASE) || (c == CL_XFER);
  endfunction

  function automatic logic cls_modify(input cmd_cls_e c);
    return (c == CL_PROG) || (c == CL_ERASE);
  endfunction

  function automatic logic cls_uses_buf(input cmd_cls_e c);
    return (c == CL_PROG) || (c == CL_XFER);
  endfunction

endpackage

// File: rtl/flash_gate_frame.sv
module flash_gate_frame (
  input  logic clk,
  input  logic rst_n,
  input  logic rst_pin_n,
  input  logic cs_n,
  input  logic cmd_vld,
  output logic slot_hit,
  output logic cs_rise
);

  logic cs_q;
  logic slot_q, slot_d;
  logic cs_fall;

  assign cs_fall  = cs_q & ~cs_n;
  assign cs_rise  = ~cs_q & cs_n;
  assign slot_hit = cmd_vld & slot_q & ~cs_n;

  always_comb begin
    slot_d = slot_q;
    if (!rst_pin_n)    slot_d = 1'b0;
    else if (cs_fall)  slot_d = 1'b1;
    else if (cs_n)     slot_d = 1'b0;
    else if (slot_hit) slot_d = 1'b0;
  end

  // cs_q resets low so a select already low at reset release opens nothing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q   <= 1'b0;
      slot_q <= 1'b0;
    end else begin
      cs_q   <= cs_n;
      slot_q <= slot_d;
    end
  end

  a_r2_slot_needs_low: assert property (@(posedge clk) disable iff (!rst_n)
    slot_q |-> $past(!cs_n));

endmodule

// File: rtl/flash_gate_judge.sv
module flash_gate_judge
  import flash_gate_pkg::*;
#(
  parameter int N_SECT = 16,
  parameter int N_BUF  = 2,
  localparam int SEC_W = $clog2(N_SECT),
  localparam int BUF_W = $clog2(N_BUF)
) (
  input  cmd_cls_e          cls,
  input  logic [SEC_W-1:0]  sect,
  input  logic [BUF_W-1:0]  bufsel,
  input  logic              wp_n,
  input  logic              busy,
  input  logic [N_BUF-1:0]  buf_lock,
  input  logic [N_SECT-1:0] sect_prot,
  input  logic              prot_on,
  output logic              ok
);

  logic sect_guarded;

  assign sect_guarded = prot_on & sect_prot[sect];

  always_comb begin
    case (cls)
      CL_BUF_ACC:          ok = ~buf_lock[bufsel];
      CL_PROG, CL_ERASE:   ok = ~busy & wp_n & ~sect_guarded;
      CL_PREG_WR:          ok = ~busy & wp_n;
      default:             ok = ~busy;
    endcase
  end

endmodule

// File: rtl/flash_gate_prot.sv
module flash_gate_prot
  import flash_gate_pkg::*;
#(
  parameter int N_SECT = 16,
  localparam int SEC_W = $clog2(N_SECT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              apply,
  input  cmd_cls_e          cls,
  input  logic [SEC_W-1:0]  sect,
  input  logic [N_SECT-1:0] wdata,
  output logic [N_SECT-1:0] sect_prot,
  output logic              prot_on
);

  logic [N_SECT-1:0] lock_q, lock_d;
  logic [N_SECT-1:0] prot_q, prot_d;
  logic              on_q, on_d;
  logic              do_lock, do_write;

  assign do_lock  = apply & (cls == CL_LOCKDN);
  assign do_write = apply & (cls == CL_PREG_WR);

  generate
    for (genvar i = 0; i < N_SECT; i++) begin : g_sect
      logic hit;
      assign hit = do_lock & (sect == SEC_W'(i));

      always_comb begin
        lock_d[i] = lock_q[i] | hit;
        prot_d[i] = prot_q[i];
        if (do_write)  prot_d[i] = wdata[i] | lock_q[i];
        else if (hit)  prot_d[i] = 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          lock_q[i] <= 1'b0;
          prot_q[i] <= 1'b0;
        end else begin
          lock_q[i] <= lock_d[i];
          prot_q[i] <= prot_d[i];
        end
      end
    end
  endgenerate

  assign on_d = on_q | (apply & (cls == CL_PROT_EN));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) on_q <= 1'b0;
    else        on_q <= on_d;
  end

  assign sect_prot = prot_q;
  assign prot_on   = on_q;

  a_r11_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(lock_q) & ~lock_q) == '0);

  a_r9_lock_in_map: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q & ~prot_q) == '0);

endmodule

// File: rtl/flash_gate_timer.sv
module flash_gate_timer #(
  parameter int OP_CYCLES = 1000,
  parameter int N_BUF     = 2,
  localparam int CNT_W    = (OP_CYCLES > 2) ? $clog2(OP_CYCLES) : 1,
  localparam int BUF_W    = $clog2(N_BUF)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             abort,
  input  logic             start,
  input  logic [BUF_W-1:0] start_buf,
  input  logic             start_uses_buf,
  output logic             busy,
  output logic [N_BUF-1:0] buf_lock
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             busy_q, busy_d;
  logic [BUF_W-1:0] sel_q, sel_d;
  logic             uv_q, uv_d;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    sel_d  = sel_q;
    uv_d   = uv_q;
    if (abort) begin
      busy_d = 1'b0;
      uv_d   = 1'b0;
    end else if (start) begin
      busy_d = 1'b1;
      cnt_d  = CNT_W'(OP_CYCLES - 1);
      sel_d  = start_buf;
      uv_d   = start_uses_buf;
    end else if (busy_q) begin
      if (cnt_q == '0) begin
        busy_d = 1'b0;
        uv_d   = 1'b0;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      sel_q  <= '0;
      uv_q   <= 1'b0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      sel_q  <= sel_d;
      uv_q   <= uv_d;
    end
  end

  generate
    for (genvar b = 0; b < N_BUF; b++) begin : g_lock
      assign buf_lock[b] = busy_q & uv_q & (sel_q == BUF_W'(b));
    end
  endgenerate

  assign busy = busy_q;

  a_r4_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy_q);

  a_r5_lock_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(buf_lock));

  a_r5_lock_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_lock != '0) |-> busy_q);

endmodule

// File: rtl/flash_op_gate.sv
module flash_op_gate
  import flash_gate_pkg::*;
#(
  parameter int N_SECT    = 16,
  parameter int N_BUF     = 2,
  parameter int OP_CYCLES = 1000,
  localparam int SEC_W    = $clog2(N_SECT),
  localparam int BUF_W    = $clog2(N_BUF)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              cmd_vld,
  input  logic [2:0]        cmd_cls,
  input  logic [SEC_W-1:0]  cmd_sect,
  input  logic [BUF_W-1:0]  cmd_buf,
  input  logic [N_SECT-1:0] cmd_wdata,
  input  logic              wp_n,
  input  logic              rst_pin_n,
  output logic              rdy_bsy,
  output logic [N_BUF-1:0]  buf_lock,
  output logic              cmd_acc,
  output logic              cmd_rej,
  output logic [N_SECT-1:0] sect_prot,
  output logic              prot_on
);

  cmd_cls_e          cls_in;
  logic              slot_hit, cs_rise, ok, busy, apply, take;
  logic              modify_req;

  logic              pend_vld_q, pend_vld_d;
  cmd_cls_e          pend_cls_q, pend_cls_d;
  logic [SEC_W-1:0]  pend_sect_q, pend_sect_d;
  logic [BUF_W-1:0]  pend_buf_q, pend_buf_d;
  logic [N_SECT-1:0] pend_data_q, pend_data_d;
  logic              acc_q, acc_d, rej_q, rej_d;

  assign cls_in     = cmd_cls_e'(cmd_cls);
  assign modify_req = cls_modify(cls_in);

  flash_gate_frame u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_pin_n (rst_pin_n),
    .cs_n      (cs_n),
    .cmd_vld   (cmd_vld),
    .slot_hit  (slot_hit),
    .cs_rise   (cs_rise)
  );

  flash_gate_judge #(.N_SECT(N_SECT), .N_BUF(N_BUF)) u_judge (
    .cls       (cls_in),
    .sect      (cmd_sect),
    .bufsel    (cmd_buf),
    .wp_n      (wp_n),
    .busy      (busy),
    .buf_lock  (buf_lock),
    .sect_prot (sect_prot),
    .prot_on   (prot_on),
    .ok        (ok)
  );

  assign take  = slot_hit & rst_pin_n;
  assign apply = cs_rise & pend_vld_q & rst_pin_n;

  always_comb begin
    pend_vld_d  = pend_vld_q;
    pend_cls_d  = pend_cls_q;
    pend_sect_d = pend_sect_q;
    pend_buf_d  = pend_buf_q;
    pend_data_d = pend_data_q;
    acc_d       = take & ok;
    rej_d       = take & ~ok;
    if (!rst_pin_n || cs_rise) begin
      pend_vld_d = 1'b0;
    end else if (take && ok) begin
      pend_vld_d  = 1'b1;
      pend_cls_d  = cls_in;
      pend_sect_d = cmd_sect;
      pend_buf_d  = cmd_buf;
      pend_data_d = cmd_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_vld_q  <= 1'b0;
      pend_cls_q  <= CL_ARR_RD;
      pend_sect_q <= '0;
      pend_buf_q  <= '0;
      pend_data_q <= '0;
      acc_q       <= 1'b0;
      rej_q       <= 1'b0;
    end else begin
      pend_vld_q  <= pend_vld_d;
      pend_cls_q  <= pend_cls_d;
      pend_sect_q <= pend_sect_d;
      pend_buf_q  <= pend_buf_d;
      pend_data_q <= pend_data_d;
      acc_q       <= acc_d;
      rej_q       <= rej_d;
    end
  end

  flash_gate_timer #(.OP_CYCLES(OP_CYCLES), .N_BUF(N_BUF)) u_timer (
    .clk            (clk),
    .rst_n          (rst_n),
    .abort          (~rst_pin_n),
    .start          (apply & cls_timed(pend_cls_q)),
    .start_buf      (pend_buf_q),
    .start_uses_buf (cls_uses_buf(pend_cls_q)),
    .busy           (busy),
    .buf_lock       (buf_lock)
  );

  flash_gate_prot #(.N_SECT(N_SECT)) u_prot (
    .clk       (clk),
    .rst_n     (rst_n),
    .apply     (apply),
    .cls       (pend_cls_q),
    .sect      (pend_sect_q),
    .wdata     (pend_data_q),
    .sect_prot (sect_prot),
    .prot_on   (prot_on)
  );

  assign rdy_bsy = ~busy;
  assign cmd_acc = acc_q;
  assign cmd_rej = rej_q;

  a_r1_verdict_after_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_acc || cmd_rej) |-> $past(cmd_vld && !cs_n));

  a_r4_busy_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rdy_bsy) |-> $past(cs_n));

  a_r7_wp_drops_modify: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_acc |-> !$past(!wp_n && modify_req));

  a_r12_pin_abort: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_pin_n |=> (rdy_bsy && (buf_lock == '0)));

endmodule

// File: tb/flash_op_gate_tb.sv
module flash_op_gate_tb;

  localparam int CLK_PERIOD = 10;
  localparam int OPC        = 24;
  localparam int NV         = 14;

  typedef struct packed {
    logic [2:0]  cls;
    logic [3:0]  sect;
    logic        bsel;
    logic [15:0] data;
    logic        wp;
    logic        acc;
    logic [15:0] prot;
    logic        pon;
    logic        busy;
  } vec_t;

  // walked in order; each entry starts from the state left by the one above
  localparam vec_t VECS [NV] = '{
    '{3'd2, 4'd3, 1'b0, 16'h0000, 1'b1, 1'b1, 16'h0000, 1'b0, 1'b1}, // R3 R4 program
    '{3'd7, 4'd0, 1'b0, 16'h0018, 1'b1, 1'b1, 16'h0018, 1'b0, 1'b0}, // R9 map write
    '{3'd2, 4'd3, 1'b0, 16'h0000, 1'b1, 1'b1, 16'h0018, 1'b0, 1'b1}, // R10 prot_on clear
    '{3'd5, 4'd0, 1'b0, 16'h0000, 1'b1, 1'b1, 16'h0018, 1'b1, 1'b0}, // R11 enable
    '{3'd3, 4'd4, 1'b0, 16'h0000, 1'b1, 1'b0, 16'h0018, 1'b1, 1'b0}, // R10 guarded sector
    '{3'd3, 4'd5, 1'b0, 16'h0000, 1'b1, 1'b1, 16'h0018, 1'b1, 1'b1}, // R10 open sector
    '{3'd2, 4'd5, 1'b0, 16'h0000, 1'b0, 1'b0, 16'h0018, 1'b1, 1'b0}, // R7 wp drops program
    '{3'd3, 4'd6, 1'b0, 16'h0000, 1'b0, 1'b0, 16'h0018, 1'b1, 1'b0}, // R7 wp drops erase
    '{3'd7, 4'd0, 1'b0, 16'hFFFF, 1'b0, 1'b0, 16'h0018, 1'b1, 1'b0}, // R9 wp refuses write
    '{3'd6, 4'd9, 1'b0, 16'h0000, 1'b0, 1'b1, 16'h0218, 1'b1, 1'b0}, // R8 R11 lockdown
    '{3'd7, 4'd0, 1'b0, 16'h0000, 1'b1, 1'b1, 16'h0200, 1'b1, 1'b0}, // R9 R11 lock survives
    '{3'd4, 4'd0, 1'b1, 16'h0000, 1'b0, 1'b1, 16'h0200, 1'b1, 1'b1}, // R3 R4 transfer under wp
    '{3'd1, 4'd0, 1'b0, 16'h0000, 1'b0, 1'b1, 16'h0200, 1'b1, 1'b0}, // R3 buffer access
    '{3'd2, 4'd9, 1'b0, 16'h0000, 1'b1, 1'b0, 16'h0200, 1'b1, 1'b0}  // R10 R11 locked sector
  };

  logic        clk, rst_n, cs_n, cmd_vld, wp_n, rst_pin_n;
  logic [2:0]  cmd_cls;
  logic [3:0]  cmd_sect;
  logic        cmd_buf;
  logic [15:0] cmd_wdata;
  logic        rdy_bsy, cmd_acc, cmd_rej, prot_on;
  logic [1:0]  buf_lock;
  logic [15:0] sect_prot;

  int n_chk  = 0;
  int n_fail = 0;

  flash_op_gate #(.N_SECT(16), .N_BUF(2), .OP_CYCLES(OPC)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cmd_vld(cmd_vld),
    .cmd_cls(cmd_cls), .cmd_sect(cmd_sect), .cmd_buf(cmd_buf),
    .cmd_wdata(cmd_wdata), .wp_n(wp_n), .rst_pin_n(rst_pin_n),
    .rdy_bsy(rdy_bsy), .buf_lock(buf_lock), .cmd_acc(cmd_acc),
    .cmd_rej(cmd_rej), .sect_prot(sect_prot), .prot_on(prot_on)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic frame(input logic [2:0] c, input logic [3:0] s, input logic b,
                       input logic [15:0] d, output logic a, output logic r);
    cs_n = 1'b0;
    tick();
    cmd_vld = 1'b1; cmd_cls = c; cmd_sect = s; cmd_buf = b; cmd_wdata = d;
    tick();
    cmd_vld = 1'b0;
    a = cmd_acc; r = cmd_rej;
    cs_n = 1'b1;
    tick();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic a, r;
    int n;
    rst_n = 1'b0; cs_n = 1'b0; cmd_vld = 1'b0; cmd_cls = 3'd0; cmd_sect = '0;
    cmd_buf = 1'b0; cmd_wdata = '0; wp_n = 1'b1; rst_pin_n = 1'b1;
    repeat (3) tick();
    // R13 reset state
    chk("R13 rdy_bsy", rdy_bsy, 1);
    chk("R13 buf_lock", buf_lock, 0);
    chk("R13 verdicts", {cmd_acc, cmd_rej}, 0);
    chk("R13 sect_prot", sect_prot, 0);
    chk("R13 prot_on", prot_on, 0);
    rst_n = 1'b1;
    repeat (2) tick();

    // R2: select low since reset, no frame open
    cmd_vld = 1'b1; cmd_cls = 3'd2;
    tick();
    cmd_vld = 1'b0;
    chk("R2 no verdict without falling edge", {cmd_acc, cmd_rej}, 0);
    cs_n = 1'b1;
    repeat (2) tick();
    chk("R2 no operation started", rdy_bsy, 1);

    // R1: strobe with select high
    cmd_vld = 1'b1; cmd_cls = 3'd0;
    tick();
    cmd_vld = 1'b0;
    chk("R1 strobe outside frame", {cmd_acc, cmd_rej}, 0);

    // R1: second strobe in the same frame is ignored
    cs_n = 1'b0;
    tick();
    cmd_vld = 1'b1; cmd_cls = 3'd0;
    tick();
    cmd_cls = 3'd7; cmd_wdata = 16'h00FF;
    chk("R1 first strobe accepted", {cmd_acc, cmd_rej}, 2'b10);
    tick();
    cmd_vld = 1'b0;
    chk("R1 second strobe silent", {cmd_acc, cmd_rej}, 0);
    cs_n = 1'b1;
    repeat (2) tick();
    chk("R1 second strobe had no effect", sect_prot, 0);

    // table walk
    foreach (VECS[i]) begin
      wp_n = VECS[i].wp;
      frame(VECS[i].cls, VECS[i].sect, VECS[i].bsel, VECS[i].data, a, r);
      chk($sformatf("R1/R3 vec %0d accept", i), a, VECS[i].acc);
      chk($sformatf("R1 vec %0d reject", i), r, !VECS[i].acc);
      chk($sformatf("R9/R11 vec %0d sect_prot", i), sect_prot, VECS[i].prot);
      chk($sformatf("R11 vec %0d prot_on", i), prot_on, VECS[i].pon);
      chk($sformatf("R4/R7 vec %0d rdy_bsy", i), rdy_bsy, !VECS[i].busy);
      repeat (OPC + 2) tick();
    end
    wp_n = 1'b1;

    // R5 R6: program into buffer 1, then frames while busy
    frame(3'd2, 4'd0, 1'b1, 16'h0, a, r);
    chk("R3 program accepted", a, 1);
    chk("R5 buffer 1 locked", buf_lock, 2'b10);
    frame(3'd1, 4'd0, 1'b0, 16'h0, a, r);
    chk("R6 other buffer usable", {a, r}, 2'b10);
    frame(3'd1, 4'd0, 1'b1, 16'h0, a, r);
    chk("R6 locked buffer refused", {a, r}, 2'b01);
    frame(3'd0, 4'd0, 1'b0, 16'h0, a, r);
    chk("R6 array read refused", {a, r}, 2'b01);
    chk("R4 busy survives select rise", rdy_bsy, 0);
    repeat (OPC + 2) tick();

    // R4 R5: erase length and no buffer lock
    frame(3'd3, 4'd1, 1'b0, 16'h0, a, r);
    chk("R5 erase locks no buffer", buf_lock, 0);
    n = 0;
    while (!rdy_bsy && n < 1000) begin
      n++;
      tick();
    end
    chk("R4 busy length", n, OPC);

    // R12: reset pin aborts busy and keeps protection
    frame(3'd2, 4'd0, 1'b0, 16'h0, a, r);
    chk("R5 buffer 0 locked", buf_lock, 2'b01);
    rst_pin_n = 1'b0;
    tick();
    chk("R12 busy ended", rdy_bsy, 1);
    chk("R12 lock cleared", buf_lock, 0);
    chk("R12 map kept", sect_prot, 16'h0200);
    chk("R12 enable kept", prot_on, 1);
    rst_pin_n = 1'b1;
    tick();

    // R12: pending map write discarded
    cs_n = 1'b0;
    tick();
    cmd_vld = 1'b1; cmd_cls = 3'd7; cmd_wdata = 16'h000F;
    tick();
    cmd_vld = 1'b0;
    chk("R9 write accepted before abort", cmd_acc, 1);
    rst_pin_n = 1'b0;
    tick();
    rst_pin_n = 1'b1;
    cs_n = 1'b1;
    repeat (2) tick();
    chk("R12 pending write discarded", sect_prot, 16'h0200);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule